// File: doc/BRIEF.md
# Instruction Breakpoint Comparator Unit

This block watches the instruction fetch stream for addresses of interest. It holds a parameterised set of address comparators. Each comparator stores a halfword-aligned code address and its own enable bit. The unit has one global enable. When the global enable is on and a presented fetch address equals the address held by any enabled comparator, the unit raises a breakpoint halt request on the next cycle. It also sets a sticky hit flag, which stays set until software clears it.

Software reaches the unit through a small word-addressed register window, with registered read data. The window holds:
- a control word, which carries the global enable and reports how the unit is built;
- a status word, which carries the hit flag;
- one word per comparator.

The control word reports the number of code comparators split across two separate fields, the number of literal comparators and a revision code. A debugger uses these fields to discover how many comparators exist. The global enable can be changed only by a write that also sets a key bit. Without the key, an errant write to the control word leaves the enable unchanged.

Top module: `bkpt_unit`

## Requirements
- R1: After a synchronous reset, the global enable is 0, every comparator word reads as zero, the hit flag reads 0 and `bkpt_req` is low.
- R2: A write to the control word (byte offset 0) changes the global enable to write-data bit 0 only if write-data bit 1 (the key) is 1. A control write with the key at 0 has no effect. The key bit always reads back as 0.
- R3: A read of the control word returns the following fields. All other bits read as 0.
  - bit 0: the global enable
  - bits 7:4: the low four bits of the comparator count
  - bits 14:12: comparator count bits 6:4
  - bits 11:8: the literal comparator count
  - bits 31:28: the revision, which is 1

  With the defaults (20 comparators, 2 literal comparators), the word reads 0x10001240 or 0x10001241.
- R4: Comparator i lives at byte offset 8 + 4·i. A write stores write-data bits 31:1 as the address and bit 0 as the comparator enable. A read returns the stored word. No other access changes it.
- R5: A word offset at or beyond 2 + the comparator count reads as zero, and writes to it change nothing. An access whose address bits 1:0 are not 00 selects no register and reads as zero.
- R6: The unit requests a breakpoint on the cycle after a fetch is presented when all of these hold during that fetch cycle:
  - the global enable is 1;
  - some comparator enable is 1;
  - fetch address bits 31:1 equal that comparator's stored bits.

  Fetch address bit 0 takes no part in the compare. The request lasts one cycle for each matching fetch.
- R7: There is no request when the global enable is 0, when the only matching comparator is disabled, when the address differs in any of bits 31:1, or when no fetch is valid.
- R8: Any request sets the hit flag, which is bit 0 of the status word at byte offset 4. Writing 1 to status bit 0 clears the flag. Writing 0 to it has no effect. The flag stays set across further hits. A hit in the same cycle as a clear leaves the flag set.
- R9: Comparators are OR-ed together: a match on any enabled comparator, including the last one, raises the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the register window |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, updated on the edge that accepts a read |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| bkpt_req | output | 1 | Breakpoint halt request, one cycle after a matching fetch |

## Verification
The compare is driven with several fetch patterns, each of which separates a correct design from a specific fault:
- an exact match;
- the same address with bit 0 set, which shows that bit 0 is excluded from the compare;
- an address one halfword away, which shows that bit 1 is included;
- a single flipped high bit, which shows that the full upper range is compared;
- the same matching address with the comparator disabled, and again with the global enable off, which separate the two enable gates.

A match on the last comparator while a different comparator holds another address shows that all comparators are OR-ed together and none is dropped at the top of the range. The register window is probed with keyless control writes, with writes past the last comparator and with misaligned offsets. These show that ignored accesses leave the stored state untouched. Finally, a hit and a clear are applied in the same cycle to pin down the priority of the sticky flag.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    localparam int WORD_W     = 32;
    localparam int CTRL_WORD  = 0;
    localparam int STAT_WORD  = 1;
    localparam int CMP_BASE   = 2;

    // Bit positions software depends on
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_KEY_BIT = 1;
    localparam int STAT_HIT_BIT = 0;
    localparam int CMP_EN_BIT   = 0;

    typedef struct packed {
        logic [WORD_W-1:1] addr_hi;
        logic              en;
    } cmp_word_t;

    // Builds the control word: enable, split comparator count, literal count, revision
    function automatic logic [WORD_W-1:0] make_ctrl_word(
        input logic en,
        input int   ncmp,
        input int   nlit,
        input int   rev
    );
        logic [WORD_W-1:0] w;
        logic [6:0]        cnt;
        w           = '0;
        cnt         = 7'(ncmp);
        w[0]        = en;
        w[7:4]      = cnt[3:0];
        w[11:8]     = 4'(nlit);
        w[14:12]    = cnt[6:4];
        w[31:28]    = 4'(rev);
        return w;
    endfunction

endpackage

// File: rtl/bpu_addr_decode.sv
module bpu_addr_decode #(
    parameter int ADDR_W  = 8,
    parameter int NUM_CMP = 20
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               sel_ctrl,
    output logic               sel_stat,
    output logic [NUM_CMP-1:0] sel_cmp
);
    import bpu_pkg::*;

    localparam int IDX_W = ADDR_W - 2;

    logic             aligned;
    logic [IDX_W-1:0] word_idx;

    assign aligned  = (addr[1:0] == 2'b00);
    assign word_idx = addr[ADDR_W-1:2];

    assign sel_ctrl = aligned && (word_idx == IDX_W'(CTRL_WORD));
    assign sel_stat = aligned && (word_idx == IDX_W'(STAT_WORD));

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_sel
        assign sel_cmp[i] = aligned && (word_idx == IDX_W'(CMP_BASE + i));
    end

endmodule

// File: rtl/bpu_comparator.sv
module bpu_comparator (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [31:0]             wdata,
    input  logic [31:0]             fetch_addr,
    output logic [31:0]             value,
    output logic                    match
);
    import bpu_pkg::*;

    cmp_word_t cmp_q;
    logic      unused_lsb;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else if (wr_en) begin
            cmp_q <= cmp_word_t'(wdata);
        end
    end

    assign value      = cmp_q;
    assign unused_lsb = fetch_addr[0];
    assign match      = cmp_q.en && (fetch_addr[31:1] == cmp_q.addr_hi);

    // R4: the stored word only changes on its own write
    a_r4_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(value));

endmodule

// File: rtl/bpu_hit_tracker.sv
module bpu_hit_tracker #(
    parameter int NUM_CMP = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               glob_en,
    input  logic               fetch_valid,
    input  logic [NUM_CMP-1:0] match_vec,
    input  logic               clr_hit,
    output logic               bkpt_req,
    output logic               hit_flag
);

    logic any_hit;

    assign any_hit = glob_en && fetch_valid && (|match_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            bkpt_req <= 1'b0;
            hit_flag <= 1'b0;
        end else begin
            bkpt_req <= any_hit;
            if (any_hit) begin
                hit_flag <= 1'b1;
            end else if (clr_hit) begin
                hit_flag <= 1'b0;
            end
        end
    end

    // R6: a request always follows a presented fetch
    a_r6_req_after_fetch: assert property (@(posedge clk) disable iff (rst)
        bkpt_req |-> $past(fetch_valid));

    // R7: no request follows a fetch seen while globally disabled
    a_r7_disabled_no_req: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !glob_en) |=> !bkpt_req);

    // R8: a request always leaves the flag set
    a_r8_flag_on_req: assert property (@(posedge clk) disable iff (rst)
        bkpt_req |-> hit_flag);

    // R8: the flag stays set unless cleared
    a_r8_sticky_holds: assert property (@(posedge clk) disable iff (rst)
        (hit_flag && !clr_hit) |=> hit_flag);

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit #(
    parameter int ADDR_W   = 8,
    parameter int NUM_CMP  = 20,
    parameter int NUM_LIT  = 2,
    parameter int REVISION = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data,
    input  logic              fetch_valid,
    input  logic [31:0]       fetch_addr,
    output logic              bkpt_req
);
    import bpu_pkg::*;

    initial begin
        assert (NUM_CMP >= 1 && NUM_CMP <= 127)
            else $error("NUM_CMP out of range");
        assert (NUM_LIT >= 0 && NUM_LIT <= 15)
            else $error("NUM_LIT out of range");
        assert ((CMP_BASE + NUM_CMP) <= (1 << (ADDR_W - 2)))
            else $error("window too small");
    end

    logic               sel_ctrl, sel_stat;
    logic [NUM_CMP-1:0] sel_cmp;
    logic [NUM_CMP-1:0] match_vec;
    logic [31:0]        cmp_val [NUM_CMP];
    logic               glob_en;
    logic               hit_flag;
    logic               wr_acc, rd_acc, ctrl_keyed, clr_hit;
    logic [31:0]        rd_mux;

    assign wr_acc     = req_valid && req_write;
    assign rd_acc     = req_valid && !req_write;
    assign ctrl_keyed = wr_acc && sel_ctrl && req_wdata[CTRL_KEY_BIT];
    assign clr_hit    = wr_acc && sel_stat && req_wdata[STAT_HIT_BIT];

    bpu_addr_decode #(.ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP)) u_dec (
        .addr     (req_addr),
        .sel_ctrl (sel_ctrl),
        .sel_stat (sel_stat),
        .sel_cmp  (sel_cmp)
    );

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        bpu_comparator u_cmp (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (wr_acc && sel_cmp[i]),
            .wdata      (req_wdata),
            .fetch_addr (fetch_addr),
            .value      (cmp_val[i]),
            .match      (match_vec[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en <= 1'b0;
        end else if (ctrl_keyed) begin
            glob_en <= req_wdata[CTRL_EN_BIT];
        end
    end

    bpu_hit_tracker #(.NUM_CMP(NUM_CMP)) u_hit (
        .clk         (clk),
        .rst         (rst),
        .glob_en     (glob_en),
        .fetch_valid (fetch_valid),
        .match_vec   (match_vec),
        .clr_hit     (clr_hit),
        .bkpt_req    (bkpt_req),
        .hit_flag    (hit_flag)
    );

    always_comb begin
        rd_mux = '0;
        if (sel_ctrl) begin
            rd_mux = make_ctrl_word(glob_en, NUM_CMP, NUM_LIT, REVISION);
        end
        if (sel_stat) begin
            rd_mux[STAT_HIT_BIT] = hit_flag;
        end
        for (int i = 0; i < NUM_CMP; i++) begin
            if (sel_cmp[i]) begin
                rd_mux = cmp_val[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_acc) begin
            rd_data <= rd_mux;
        end
    end

    // R2: a keyless control write leaves the enable unchanged
    a_r2_keyless_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && sel_ctrl && !req_wdata[CTRL_KEY_BIT]) |=> $stable(glob_en));

    // R2: the enable only moves on a keyed control write
    a_r2_enable_needs_key: assert property (@(posedge clk) disable iff (rst)
        !ctrl_keyed |=> $stable(glob_en));

endmodule

// File: tb/bkpt_unit_bench.sv
module bkpt_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int NUM_CMP    = 20;
    localparam logic [31:0] CTRL_ID = 32'h1000_1240;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       rd_data;
    logic              fetch_valid = 1'b0;
    logic [31:0]       fetch_addr = '0;
    logic              bkpt_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bkpt_unit #(.ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP)) u_bkpt_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .bkpt_req(bkpt_req)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk); #1;
        d = rd_data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Presents one fetch and returns bkpt_req seen after the following edge
    task automatic fetch(input logic [31:0] a, output logic hit);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = a;
        @(posedge clk); #1;
        hit = bkpt_req;
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    function automatic logic [ADDR_W-1:0] cmp_off(input int i);
        return ADDR_W'(8 + 4*i);
    endfunction

    task automatic t_reset_state();
        logic [31:0] d;
        check("R1 bkpt_req after reset", {31'b0, bkpt_req}, 32'h0);
        rd(8'h00, d); check("R1 control after reset", d, CTRL_ID);
        rd(8'h04, d); check("R1 status after reset", d, 32'h0);
        rd(cmp_off(0), d); check("R1 comparator 0 after reset", d, 32'h0);
        rd(cmp_off(NUM_CMP-1), d); check("R1 last comparator after reset", d, 32'h0);
    endtask

    task automatic t_control_key();
        logic [31:0] d;
        wr(8'h00, 32'h0000_0001);
        rd(8'h00, d); check("R2 keyless enable ignored", d, CTRL_ID);
        wr(8'h00, 32'h0000_0003);
        rd(8'h00, d); check("R2 keyed enable, R3 fields", d, CTRL_ID | 32'h1);
        wr(8'h00, 32'hFFFF_FFFC);
        rd(8'h00, d); check("R2 keyless disable ignored", d, CTRL_ID | 32'h1);
    endtask

    task automatic t_comparator_regs();
        logic [31:0] d;
        wr(cmp_off(0), 32'h0000_1235);
        wr(cmp_off(NUM_CMP-1), 32'h8000_4001);
        rd(cmp_off(0), d); check("R4 comparator 0 readback", d, 32'h0000_1235);
        rd(cmp_off(NUM_CMP-1), d); check("R4 last comparator readback", d, 32'h8000_4001);
        rd(cmp_off(1), d); check("R4 neighbour untouched", d, 32'h0);
    endtask

    task automatic t_out_of_range();
        logic [31:0] d;
        wr(cmp_off(NUM_CMP), 32'hDEAD_BEEF);
        rd(cmp_off(NUM_CMP), d); check("R5 beyond last reads zero", d, 32'h0);
        rd(cmp_off(0), d); check("R5 no alias into comparator 0", d, 32'h0000_1235);
        wr(cmp_off(1) + 8'd1, 32'h1111_1111);
        rd(cmp_off(1), d); check("R5 misaligned write ignored", d, 32'h0);
        rd(8'h01, d); check("R5 misaligned read zero", d, 32'h0);
    endtask

    task automatic t_match_patterns();
        logic h;
        logic [31:0] d;
        fetch(32'h0000_1234, h); check("R6 exact match", {31'b0, h}, 32'h1);
        @(posedge clk); #1;
        check("R6 request lasts one cycle", {31'b0, bkpt_req}, 32'h0);
        fetch(32'h0000_1235, h); check("R6 bit0 ignored", {31'b0, h}, 32'h1);
        fetch(32'h0000_1236, h); check("R7 bit1 differs", {31'b0, h}, 32'h0);
        fetch(32'h1000_1234, h); check("R7 high bit differs", {31'b0, h}, 32'h0);
        fetch(32'h8000_4000, h); check("R9 last comparator match", {31'b0, h}, 32'h1);
        wr(cmp_off(0), 32'h0000_1234);
        fetch(32'h0000_1234, h); check("R7 comparator disabled", {31'b0, h}, 32'h0);
        wr(cmp_off(0), 32'h0000_1235);
        wr(8'h00, 32'h0000_0002);
        rd(8'h00, d); check("R2 keyed disable", d, CTRL_ID);
        fetch(32'h0000_1234, h); check("R7 global disabled", {31'b0, h}, 32'h0);
        wr(8'h00, 32'h0000_0003);
    endtask

    task automatic t_sticky_flag();
        logic [31:0] d;
        logic h;
        rd(8'h04, d); check("R8 flag set by hit", d, 32'h1);
        wr(8'h04, 32'h0000_0000);
        rd(8'h04, d); check("R8 write 0 no effect", d, 32'h1);
        wr(8'h04, 32'h0000_0001);
        rd(8'h04, d); check("R8 write 1 clears", d, 32'h0);
        fetch(32'h0000_1236, h);
        rd(8'h04, d); check("R8 miss leaves flag clear", d, 32'h0);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = 32'h0000_1234;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h04; req_wdata = 32'h1;
        @(negedge clk);
        fetch_valid = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        rd(8'h04, d); check("R8 hit wins over clear", d, 32'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset_state();
        t_control_key();
        t_comparator_regs();
        t_out_of_range();
        t_match_patterns();
        t_sticky_flag();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule